// File: doc/BRIEF.md
# Host-Bus Firmware Read to Serial Flash Bridge

This block sits between a host on the LPC bus and a serial NOR flash on a four-wire SPI link. It acts as an LPC target for memory read cycles. When such a cycle arrives and the bridge is enabled, it captures the low 24 bits of the host address. It then opens one SPI transaction made of a programmable read opcode, the three address bytes, a single dummy byte and `RD_BYTES` read bytes. `RD_BYTES` can be 1 to 4 and defaults to one byte.

While the flash transfer runs, the bridge holds the host with long-wait SYNC nibbles. Once every read byte has been shifted into its small receive buffer, it answers with a Ready SYNC, the data nibbles and the turnaround. Everything runs on the LPC clock. The SPI clock is that clock divided by two, in mode 0.

A frame strobe from the host in the middle of a cycle aborts the cycle. Any flash transfer in progress is cut short and the chip select is released.

Top module: `lpc_spi_rd_bridge`

## Requirements
- R1: While reset is held and right after it, `spi_cs_n` is 1, `spi_sck` is 0 and `lad_oe` is 0.
- R2: A cycle starts when `lframe_n` is 0 with `lad_in` = 0000. The next nibble 0100 marks a memory read. Eight address nibbles follow, most significant first, then two host turnaround cycles. The bridge returns the flash bytes stored at the low 24 address bits and the `RD_BYTES-1` addresses above them.
- R3: The first byte sent on `spi_mosi` after `spi_cs_n` falls equals `rd_opcode`.
- R4: Address bits 23 down to 0 follow the opcode, most significant bit first.
- R5: After the address, one dummy byte of value 0x00 is sent. `spi_cs_n` then stays low for exactly 8*(5+`RD_BYTES`) rising edges of `spi_sck` in total.
- R6: In the sync phase, `lad_out` = 0110 with `lad_oe` = 1 on every cycle until the flash data has been captured, which takes at least one cycle.
- R7: When reception is complete, the bridge drives one SYNC nibble 0000. It then drives the data nibbles, each byte low nibble first and bytes in address order, then one cycle of 1111. After that cycle, `lad_oe` drops.
- R8: If `rd_en` is 0 when the cycle-type nibble arrives, the cycle is ignored. No SPI transfer occurs and LAD is never driven.
- R9: Any cycle-type nibble other than 0100 (for example 0000 I/O read or 0110 memory write) is ignored in the same way.
- R10: SPI mode 0. `spi_sck` is low whenever `spi_cs_n` is high. `spi_mosi` changes only while `spi_sck` is low. One SPI bit lasts two clock cycles.
- R11: Between transactions, `spi_cs_n` stays high for at least two clock cycles.
- R12: If `lframe_n` goes low while the bridge is driving LAD or waiting on the flash, the next cycle has `lad_oe` = 0 and `spi_cs_n` = 1. A following cycle is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LPC clock, also the SPI timing base |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Enables translation of memory reads |
| rd_opcode | input | 8 | SPI read command byte (0x0B for fast read) |
| lframe_n | input | 1 | LPC frame strobe, active low |
| lad_in | input | 4 | LAD nibble driven by the host |
| lad_out | output | 4 | LAD nibble driven by the bridge |
| lad_oe | output | 1 | LAD output enable of the bridge |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | SPI clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bound checker watches the SPI mode-0 rules on every cycle: the clock stays low while deselected and at select edges, and MOSI stays stable while the clock is high. It also checks the minimum deselect time and that a frame strobe during a driven phase releases LAD and the chip select one cycle later. Other properties depend on the data itself and can only be shown by the directed scenarios against a behavioural flash: the opcode, address order, dummy byte and bit count on the wire, and the SYNC wait-then-Ready sequence. The same goes for the nibble order of the returned byte, the silence of disabled or foreign cycles, and recovery after an abort.

// File: rtl/lpc_spi_pkg.sv
`timescale 1ns/1ps
package lpc_spi_pkg;
  localparam logic [3:0] LAD_START  = 4'h0;
  localparam logic [3:0] LAD_MEMRD  = 4'h4;
  localparam logic [3:0] SYNC_LWAIT = 4'h6;
  localparam logic [3:0] SYNC_READY = 4'h0;
  localparam logic [3:0] LAD_TURN   = 4'hF;
  localparam int unsigned HDR_BYTES = 5;   // opcode, 3 address bytes, dummy

  typedef enum logic [2:0] {
    LP_IDLE, LP_CYC, LP_ADDR, LP_TARI, LP_SYNC, LP_DATA, LP_TARO
  } lpc_st_e;

  typedef enum logic [1:0] {
    SP_IDLE, SP_XFER, SP_GAP
  } spi_st_e;
endpackage

// File: rtl/lpc_tgt_fsm.sv
`timescale 1ns/1ps
module lpc_tgt_fsm
  import lpc_spi_pkg::*;
#(
  parameter int unsigned RD_BYTES = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lframe_n,
  input  logic [3:0]            lad_in,
  input  logic                  rd_en,
  input  logic                  rx_ready,
  input  logic [8*RD_BYTES-1:0] rx_data,
  output logic [3:0]            lad_out,
  output logic                  lad_oe,
  output logic                  xfer_start,
  output logic                  xfer_abort,
  output logic [23:0]           xfer_addr
);
  localparam int unsigned NIB     = 2 * RD_BYTES;
  localparam int unsigned CNT_MAX = (NIB > 8) ? NIB : 8;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX);

  lpc_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [19:0]      addr_sr_q;
  logic             addr_en;
  logic [3:0]       data_nib;

  // next state
  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    xfer_start = 1'b0;
    xfer_abort = 1'b0;
    if (!lframe_n) begin
      xfer_abort = (st_q == LP_TARI) || (st_q == LP_SYNC) ||
                   (st_q == LP_DATA) || (st_q == LP_TARO);
      st_d  = (lad_in == LAD_START) ? LP_CYC : LP_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        LP_IDLE: st_d = LP_IDLE;
        LP_CYC: begin
          st_d  = (lad_in == LAD_MEMRD && rd_en) ? LP_ADDR : LP_IDLE;
          cnt_d = '0;
        end
        LP_ADDR: begin
          if (cnt_q == CNT_W'(7)) begin
            st_d       = LP_TARI;
            cnt_d      = '0;
            xfer_start = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        LP_TARI: begin
          if (cnt_q == CNT_W'(1)) begin
            st_d  = LP_SYNC;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        LP_SYNC: begin
          if (rx_ready) st_d = LP_DATA;
          cnt_d = '0;
        end
        LP_DATA: begin
          if (cnt_q == CNT_W'(NIB - 1)) begin
            st_d  = LP_TARO;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        LP_TARO: begin
          if (cnt_q == CNT_W'(1)) begin
            st_d  = LP_IDLE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: st_d = LP_IDLE;
      endcase
    end
  end

  assign addr_en   = lframe_n && (st_q == LP_ADDR);
  assign xfer_addr = {addr_sr_q, lad_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= LP_IDLE;
      cnt_q     <= '0;
      addr_sr_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (addr_en) addr_sr_q <= {addr_sr_q[15:0], lad_in};
    end
  end

  // nibble select: nibble k of the buffer is byte k/2, low half first
  always_comb begin
    data_nib = LAD_TURN;
    for (int i = 0; i < NIB; i++) begin
      if (cnt_q == CNT_W'(i)) data_nib = rx_data[4*i +: 4];
    end
  end

  always_comb begin
    lad_oe  = 1'b0;
    lad_out = LAD_TURN;
    unique case (st_q)
      LP_SYNC: begin
        lad_oe  = 1'b1;
        lad_out = rx_ready ? SYNC_READY : SYNC_LWAIT;
      end
      LP_DATA: begin
        lad_oe  = 1'b1;
        lad_out = data_nib;
      end
      LP_TARO: lad_oe = (cnt_q == '0);
      default: lad_oe = 1'b0;
    endcase
  end
endmodule

// File: rtl/spi_rd_master.sv
`timescale 1ns/1ps
module spi_rd_master
  import lpc_spi_pkg::*;
#(
  parameter int unsigned RD_BYTES = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        abort,
  input  logic [23:0] addr,
  input  logic [7:0]  opcode,
  input  logic        spi_miso,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  output logic        rx_cap,
  output logic        rx_done
);
  localparam int unsigned HDR_BITS = 8 * HDR_BYTES;
  localparam int unsigned TOT_BITS = 8 * (HDR_BYTES + RD_BYTES);
  localparam int unsigned BIT_W    = $clog2(TOT_BITS);

  spi_st_e             st_q, st_d;
  logic                cs_q, cs_d;
  logic                sck_q, sck_d;
  logic [HDR_BITS-1:0] tx_q, tx_d;
  logic [BIT_W-1:0]    bit_q, bit_d;
  logic                gap_q, gap_d;

  always_comb begin
    st_d    = st_q;
    cs_d    = cs_q;
    sck_d   = sck_q;
    tx_d    = tx_q;
    bit_d   = bit_q;
    gap_d   = gap_q;
    rx_cap  = 1'b0;
    rx_done = 1'b0;
    unique case (st_q)
      SP_IDLE: begin
        if (start && !abort) begin
          st_d  = SP_XFER;
          cs_d  = 1'b0;
          sck_d = 1'b0;
          bit_d = '0;
          tx_d  = {opcode, addr, 8'h00};  // address register loaded here
        end
      end
      SP_XFER: begin
        if (abort) begin
          st_d  = SP_GAP;
          cs_d  = 1'b1;
          sck_d = 1'b0;
          gap_d = 1'b0;
        end else if (!sck_q) begin
          sck_d  = 1'b1;
          rx_cap = (bit_q >= BIT_W'(HDR_BITS));
        end else begin
          sck_d = 1'b0;
          if (bit_q == BIT_W'(TOT_BITS - 1)) begin
            st_d    = SP_GAP;
            cs_d    = 1'b1;
            gap_d   = 1'b0;
            rx_done = 1'b1;
          end else begin
            bit_d = bit_q + 1'b1;
            tx_d  = {tx_q[HDR_BITS-2:0], 1'b0};
          end
        end
      end
      SP_GAP: begin
        if (gap_q) st_d = SP_IDLE;
        gap_d = 1'b1;
      end
      default: st_d = SP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SP_IDLE;
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
      tx_q  <= '0;
      bit_q <= '0;
      gap_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cs_q  <= cs_d;
      sck_q <= sck_d;
      tx_q  <= tx_d;
      bit_q <= bit_d;
      gap_q <= gap_d;
    end
  end

  assign spi_cs_n = cs_q;
  assign spi_sck  = sck_q;
  assign spi_mosi = tx_q[HDR_BITS-1];
endmodule

// File: rtl/spi_rx_buf.sv
`timescale 1ns/1ps
module spi_rx_buf #(
  parameter int unsigned RD_BYTES = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  cap,
  input  logic                  din,
  input  logic                  done,
  output logic [8*RD_BYTES-1:0] data,
  output logic                  ready
);
  localparam int unsigned W = 8 * RD_BYTES;

  logic [W-1:0] sr_q;
  logic         rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      rdy_q <= 1'b0;
    end else begin
      if (cap) sr_q <= {sr_q[W-2:0], din};
      if (clr)       rdy_q <= 1'b0;
      else if (done) rdy_q <= 1'b1;
    end
  end

  // first byte received sits in the top of the shifter; present it as byte 0
  for (genvar i = 0; i < RD_BYTES; i++) begin : g_swap
    assign data[8*i +: 8] = sr_q[8*(RD_BYTES-1-i) +: 8];
  end

  assign ready = rdy_q;
endmodule

// File: rtl/lpc_spi_rd_bridge.sv
`timescale 1ns/1ps
module lpc_spi_rd_bridge #(
  parameter int unsigned RD_BYTES = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic [7:0] rd_opcode,
  input  logic       lframe_n,
  input  logic [3:0] lad_in,
  output logic [3:0] lad_out,
  output logic       lad_oe,
  output logic       spi_cs_n,
  output logic       spi_sck,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  logic [1:0]            rst_sync_q;
  logic                  rst_n_s;
  logic                  start, abort, cap, done, ready;
  logic [23:0]           addr;
  logic [8*RD_BYTES-1:0] rx_data;

  // asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  lpc_tgt_fsm #(.RD_BYTES(RD_BYTES)) u_lpc (
    .clk(clk), .rst_n(rst_n_s), .lframe_n(lframe_n), .lad_in(lad_in),
    .rd_en(rd_en), .rx_ready(ready), .rx_data(rx_data),
    .lad_out(lad_out), .lad_oe(lad_oe),
    .xfer_start(start), .xfer_abort(abort), .xfer_addr(addr)
  );

  spi_rd_master #(.RD_BYTES(RD_BYTES)) u_spi (
    .clk(clk), .rst_n(rst_n_s), .start(start), .abort(abort),
    .addr(addr), .opcode(rd_opcode), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .rx_cap(cap), .rx_done(done)
  );

  spi_rx_buf #(.RD_BYTES(RD_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n_s), .clr(start | abort), .cap(cap),
    .din(spi_miso), .done(done), .data(rx_data), .ready(ready)
  );
endmodule

// File: rtl/lpc_spi_rd_bridge_chk.sv
`timescale 1ns/1ps
module lpc_spi_rd_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lframe_n,
  input logic       lad_oe,
  input logic       spi_cs_n,
  input logic       spi_sck,
  input logic       spi_mosi
);
  a_r10_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  a_r10_sck_low_at_select: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> !spi_sck);

  a_r10_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> $stable(spi_mosi));

  a_r11_cs_min_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);

  a_r12_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
    (lad_oe && !lframe_n) |=> (!lad_oe && spi_cs_n));
endmodule

bind lpc_spi_rd_bridge lpc_spi_rd_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_oe(lad_oe),
  .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
);

// File: tb/sim_lpc_spi_rd_bridge.sv
`timescale 1ns/1ps
module sim_lpc_spi_rd_bridge;
  localparam int RB  = 1;
  localparam int TOT = 8 * (5 + RB);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_opcode = 8'h0B;
  logic       lframe_n = 1'b1;
  logic [3:0] lad_in = 4'hF;
  logic [3:0] lad_out;
  logic       lad_oe;
  logic       spi_cs_n, spi_sck, spi_mosi;
  logic       spi_miso = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;   // 250 MHz

  lpc_spi_rd_bridge #(.RD_BYTES(RB)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_opcode(rd_opcode),
    .lframe_n(lframe_n), .lad_in(lad_in), .lad_out(lad_out), .lad_oe(lad_oe),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  // ---------------- behavioural flash ----------------
  function automatic logic [7:0] fmem(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'hA5;
  endfunction

  int          cyc = 0;
  int          bitc = 0;
  logic [63:0] flog = '0;
  logic [23:0] faddr = '0;
  int          last_bits = 0;
  logic [63:0] last_log = '0;
  int          cs_falls = 0;
  bit          mode_err = 1'b0;
  int          cs_rise_cyc = 0;
  int          min_gap = 100000;

  always @(posedge clk) cyc++;

  always @(negedge spi_cs_n) begin
    bitc = 0;
    flog = '0;
    cs_falls++;
    if (spi_sck) mode_err = 1'b1;
    if (cyc - cs_rise_cyc < min_gap) min_gap = cyc - cs_rise_cyc;
  end

  always @(posedge spi_cs_n) begin
    last_bits   = bitc;
    last_log    = flog;
    cs_rise_cyc = cyc;
    if (spi_sck === 1'b1) mode_err = 1'b1;
  end

  always @(posedge spi_sck) begin
    if (spi_cs_n === 1'b0) begin
      flog = {flog[62:0], spi_mosi};
      bitc++;
      if (bitc == 32) faddr = flog[23:0];
    end
  end

  always @(negedge spi_sck) begin
    if (spi_cs_n === 1'b0 && bitc >= 40 && bitc < TOT) begin
      automatic int idx = bitc - 40;
      automatic logic [7:0] b = fmem(faddr + 24'(idx / 8));
      spi_miso = b[7 - (idx % 8)];
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drv(input logic fr, input logic [3:0] nib);
    @(negedge clk);
    lframe_n = fr;
    lad_in   = nib;
  endtask

  task automatic send_header(input logic [3:0] ctype, input logic [31:0] a);
    drv(1'b0, 4'h0);
    drv(1'b1, ctype);
    for (int i = 7; i >= 0; i--) drv(1'b1, a[4*i +: 4]);
    drv(1'b1, 4'hF);
    drv(1'b1, 4'hF);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(spi_cs_n === 1'b1 && spi_sck === 1'b0 && lad_oe === 1'b0, "R1 reset outputs",
        {29'd0, spi_cs_n, spi_sck, lad_oe}, 32'h4);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(spi_cs_n === 1'b1 && spi_sck === 1'b0 && lad_oe === 1'b0, "R1 after release",
        {29'd0, spi_cs_n, spi_sck, lad_oe}, 32'h4);
  endtask

  task automatic t_read(input logic [31:0] a, input logic [7:0] op);
    int  waits = 0;
    bit  ok_sync = 1'b1;
    logic [23:0] a24 = a[23:0];
    rd_en = 1'b1;
    rd_opcode = op;
    send_header(4'h4, a);
    // sync phase: long waits (R6) then ready (R7)
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (lad_oe !== 1'b1) begin ok_sync = 1'b0; break; end
      if (lad_out === 4'h6) waits++;
      else if (lad_out === 4'h0) break;
      else begin ok_sync = 1'b0; break; end
    end
    chk(ok_sync, "R7 ready sync after waits", {27'd0, lad_oe, lad_out}, 32'h10);
    chk(waits >= 1, "R6 long-wait sync held while busy", waits, 1);
    for (int j = 0; j < 2 * RB; j++) begin
      automatic logic [7:0] eb = fmem(a24 + 24'(j / 2));
      automatic logic [3:0] en = (j % 2 == 0) ? eb[3:0] : eb[7:4];
      @(negedge clk);
      chk(lad_oe === 1'b1 && lad_out === en, "R2 R7 data nibble low first",
          {27'd0, lad_oe, lad_out}, {27'd0, 1'b1, en});
    end
    @(negedge clk);
    chk(lad_oe === 1'b1 && lad_out === 4'hF, "R7 turnaround 1111",
        {27'd0, lad_oe, lad_out}, 32'h1F);
    @(negedge clk);
    chk(lad_oe === 1'b0, "R7 release after turnaround", lad_oe, 0);
    lad_in = 4'hF;
    repeat (4) @(negedge clk);
    chk(last_log[8*(4+RB) +: 8] === op, "R3 opcode byte", last_log[8*(4+RB) +: 8], op);
    chk(last_log[8*(1+RB) +: 24] === a24, "R4 address msb first",
        last_log[8*(1+RB) +: 24], a24);
    chk(last_log[8*RB +: 8] === 8'h00, "R5 dummy byte", last_log[8*RB +: 8], 0);
    chk(last_bits == TOT, "R5 bit count", last_bits, TOT);
    chk(!mode_err, "R10 sck low at select edges", mode_err, 0);
  endtask

  task automatic t_ignored(input bit en, input logic [3:0] ctype, input string req);
    int  falls0 = cs_falls;
    bit  drove = 1'b0;
    rd_en = en;
    drv(1'b0, 4'h0);
    drv(1'b1, ctype);
    for (int i = 0; i < 40; i++) begin
      drv(1'b1, (i < 8) ? 4'h3 : 4'hF);
      if (lad_oe !== 1'b0) drove = 1'b1;
    end
    chk(!drove, {req, " LAD not driven"}, drove, 0);
    chk(cs_falls == falls0, {req, " no SPI transfer"}, cs_falls - falls0, 0);
    rd_en = 1'b1;
  endtask

  task automatic t_abort;
    rd_en = 1'b1;
    rd_opcode = 8'h0B;
    send_header(4'h4, 32'hFF00_1234);
    repeat (10) @(negedge clk);
    chk(spi_cs_n === 1'b0 && lad_oe === 1'b1, "R12 transfer in progress",
        {30'd0, spi_cs_n, lad_oe}, 32'h1);
    drv(1'b0, 4'hF);
    @(negedge clk);
    chk(spi_cs_n === 1'b1 && lad_oe === 1'b0, "R12 abort releases",
        {30'd0, spi_cs_n, lad_oe}, 32'h2);
    drv(1'b1, 4'hF);
    repeat (3) @(negedge clk);
    t_read(32'hFFAB_CDEF, 8'h0B);
  endtask

  initial begin
    #400000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_read(32'hFF12_3456, 8'h0B);
    t_read(32'h0000_0000, 8'h0B);
    t_read(32'hFFFF_FFFF, 8'h3B);
    t_ignored(1'b0, 4'h4, "R8 disabled");
    t_ignored(1'b1, 4'h0, "R9 io read");
    t_ignored(1'b1, 4'h6, "R9 mem write");
    t_abort();
    t_read(32'h00C0_FFEE, 8'h0B);
    chk(min_gap >= 2, "R11 deselect gap", min_gap, 2);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule